// File: doc/BRIEF.md
# Synchronous Serial Port Master

This block is a register-mapped serial port master. A host writes frames into an eight-entry transmit queue through a small word-addressed register bus. A shift engine sends each frame most-significant bit first on a serial data output, with a serial clock and an active-low frame select. It collects the returning bits from the serial data input, or from its own output when loopback is selected, into an eight-entry receive queue that the host drains through the same data register. Frames can be 4 to 16 bits wide. Clock polarity, clock phase and the serial clock rate come from two configuration registers.

Three interrupt sources are merged onto one request line, and each has its own enable: the receive queue is at least half full, the transmit queue is at most half full, and a receive overrun has happened. An overrun happens when a frame completes while the receive queue is already full. That frame is dropped and a sticky flag is raised. Any write to the interrupt identify address clears the flag.

Top module: `sspm_top`

## Requirements
- R1: After reset the status register (offset 0x0C) reads 0x03, the frame select is high, the serial clock is low, the interrupt line is low and control 1 (offset 0x04) reads 0.
- R2: Control 0 (offset 0x00, 16 bits) and control 1 (7 bits) read back what was written, with each byte written only when its byte enable is set. The prescale register (offset 0x10) reads back with bit 0 forced to 0.
- R3: The frame width is the control 0 bits 3:0 code plus one; codes below 3 give 4 bits. Each frame goes out MSB first while the frame select is low, and the frame select returns high between frames.
- R4: The serial clock half-period is (prescale/2)·(SCR+1) system clocks. SCR is control 0 bits 15:8, and a prescale below 2 counts as 2.
- R5: Control 0 bit 7 sets the idle level of the serial clock. Control 0 bit 6 picks the sampling edge: clear means the edge leaving idle, set means the edge returning to idle. Output data changes on the opposite edge.
- R6: With control 1 bit 3 set, the receiver takes its own output bit; otherwise it takes the serial data input pin.
- R7: Each queue holds 8 frames. Status bit 0 means transmit empty, bit 1 transmit not full, bit 2 receive not empty, bit 3 receive full. A data write (offset 0x08) to a full transmit queue is dropped.
- R8: A frame that completes with the receive queue full is discarded and sets identify bit 2 (offset 0x14). Any write to offset 0x14 clears it.
- R9: Identify bit 0 is the receive queue holding at least 4 frames, gated by control 1 bit 0. Bit 1 is the transmit queue holding at most 4 frames, gated by control 1 bit 1. Bit 2 is gated by control 1 bit 2. The interrupt line is the OR of the three.
- R10: Status bit 4 (busy) is high while frames wait in the transmit queue or a frame is being shifted, including its closing half-periods.
- R11: With control 1 bit 4 clear, nothing is shifted: the frame select stays high, the serial clock stays idle and queued frames stay queued. Writing 0 to control 1 disables the port.
- R12: A data read pops the receive queue and returns the frame zero-extended to 16 bits. A read of an empty queue returns 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous reset, active low |
| busSel | input | 1 | Register access strobe |
| busWrite | input | 1 | 1 for write, 0 for read |
| busAddr | input | 5 | Byte address of the register |
| busByteEn | input | 2 | Byte enables for the halfword |
| busWrData | input | 16 | Write data |
| busRdData | output | 16 | Read data, valid during a read access |
| irq | output | 1 | Merged interrupt request |
| sclk | output | 1 | Serial clock |
| mosi | output | 1 | Serial data out |
| ssn | output | 1 | Frame select, active low |
| miso | input | 1 | Serial data in |

## Verification
Every combination of clock polarity and phase is driven with several distinct byte patterns under loopback. A serial-side monitor reconstructs each frame at the sampling edge the mode implies, so a wrong edge or a wrong bit order shows up as a corrupted word. Frame widths of 16 bits, 4 bits and a below-minimum code are sent with stray upper bits, which separates masking from width selection. With loopback off, the serial input is the inverse of the output, so a pin-path frame cannot be mistaken for a loopback frame. A final sequence fills the transmit queue while the port is disabled, then releases it into a full receive queue to force an overrun, walking through every interrupt threshold on the way.

// File: rtl/sspm_pkg.sv
package sspm_pkg;
  localparam int FRAME_W = 16;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_XFER,
    ST_HOLD,
    ST_GAP
  } shiftState_t;

  // Strobes from control to datapath, one cycle each.
  typedef struct packed {
    logic hostPush;
    logic hostPop;
    logic load;
    logic shiftOut;
    logic sampleIn;
    logic rxPush;
  } dpStrobe_t;
endpackage

// File: rtl/sspm_fifo.sv
module sspm_fifo #(
  parameter int DEPTH = 8,
  parameter int WIDTH = 16,
  parameter int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             push,
  input  logic [WIDTH-1:0] pushData,
  input  logic             pop,
  output logic [WIDTH-1:0] headData,
  output logic [CNT_W-1:0] count,
  output logic             empty,
  output logic             full
);
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic [WIDTH-1:0] mem [DEPTH];
  logic [PTR_W-1:0] wrPtr, rdPtr;
  logic doPush, doPop;

  assign empty   = (count == '0);
  assign full    = (count == CNT_W'(DEPTH));
  assign doPush  = push && !full;
  assign doPop   = pop && !empty;
  assign headData = mem[rdPtr];

  function automatic logic [PTR_W-1:0] nextPtr(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : p + PTR_W'(1);
  endfunction

  always_ff @(posedge clk) begin
    if (doPush) mem[wrPtr] <= pushData;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wrPtr <= '0;
      rdPtr <= '0;
      count <= '0;
    end else begin
      if (doPush) wrPtr <= nextPtr(wrPtr);
      if (doPop)  rdPtr <= nextPtr(rdPtr);
      case ({doPush, doPop})
        2'b10:   count <= count + CNT_W'(1);
        2'b01:   count <= count - CNT_W'(1);
        default: count <= count;
      endcase
    end
  end

  a_r7_count_bounded: assert property (@(posedge clk) disable iff (!rstN)
    count <= CNT_W'(DEPTH));
  a_r7_full_holds: assert property (@(posedge clk) disable iff (!rstN)
    (full && push && !pop) |=> (count == CNT_W'(DEPTH)));
endmodule

// File: rtl/sspm_dpath.sv
module sspm_dpath
  import sspm_pkg::*;
#(
  parameter int FIFO_DEPTH = 8,
  parameter int CNT_W = $clog2(FIFO_DEPTH + 1)
) (
  input  logic               clk,
  input  logic               rstN,
  input  dpStrobe_t          strobe,
  input  logic [FRAME_W-1:0] hostData,
  input  logic [4:0]         frameBits,
  input  logic               loopback,
  input  logic               misoIn,
  output logic               mosiOut,
  output logic [FRAME_W-1:0] rxHead,
  output logic [CNT_W-1:0]   txCount,
  output logic [CNT_W-1:0]   rxCount,
  output logic               txEmpty,
  output logic               txFull,
  output logic               rxEmpty,
  output logic               rxFull
);
  logic [FRAME_W-1:0] txHead, txShift, rxShift, rxNext, rxFrame;
  logic [31:0] maskWide;
  logic inBit;

  sspm_fifo #(.DEPTH(FIFO_DEPTH), .WIDTH(FRAME_W), .CNT_W(CNT_W)) txFifo_i (
    .clk(clk), .rstN(rstN), .push(strobe.hostPush), .pushData(hostData),
    .pop(strobe.load), .headData(txHead), .count(txCount),
    .empty(txEmpty), .full(txFull));

  sspm_fifo #(.DEPTH(FIFO_DEPTH), .WIDTH(FRAME_W), .CNT_W(CNT_W)) rxFifo_i (
    .clk(clk), .rstN(rstN), .push(strobe.rxPush), .pushData(rxFrame),
    .pop(strobe.hostPop), .headData(rxHead), .count(rxCount),
    .empty(rxEmpty), .full(rxFull));

  assign mosiOut  = txShift[FRAME_W-1];
  assign inBit    = loopback ? mosiOut : misoIn;
  assign rxNext   = strobe.sampleIn ? {rxShift[FRAME_W-2:0], inBit} : rxShift;
  assign maskWide = (32'd1 << frameBits) - 32'd1;
  assign rxFrame  = rxNext & maskWide[FRAME_W-1:0];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      txShift <= '0;
      rxShift <= '0;
    end else begin
      if (strobe.load)
        txShift <= txHead << (5'(FRAME_W) - frameBits);
      else if (strobe.shiftOut)
        txShift <= txShift << 1;
      if (strobe.load)
        rxShift <= '0;
      else
        rxShift <= rxNext;
    end
  end

  a_r3_load_has_frame: assert property (@(posedge clk) disable iff (!rstN)
    strobe.load |-> !txEmpty);
  a_r8_push_not_full: assert property (@(posedge clk) disable iff (!rstN)
    strobe.rxPush |-> !rxFull);
endmodule

// File: rtl/sspm_ctrl.sv
module sspm_ctrl
  import sspm_pkg::*;
#(
  parameter int FIFO_DEPTH = 8,
  parameter int CNT_W = $clog2(FIFO_DEPTH + 1)
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               busSel,
  input  logic               busWrite,
  input  logic [4:0]         busAddr,
  input  logic [1:0]         busByteEn,
  input  logic [15:0]        busWrData,
  output logic [15:0]        busRdData,
  output logic               irq,
  output logic               sclk,
  output logic               ssn,
  output dpStrobe_t          strobe,
  output logic [FRAME_W-1:0] hostData,
  output logic [4:0]         frameBits,
  output logic               loopback,
  input  logic [FRAME_W-1:0] rxHead,
  input  logic [CNT_W-1:0]   txCount,
  input  logic [CNT_W-1:0]   rxCount,
  input  logic               txEmpty,
  input  logic               txFull,
  input  logic               rxEmpty,
  input  logic               rxFull
);
  localparam logic [2:0] IDX_CFG0 = 3'd0;
  localparam logic [2:0] IDX_CFG1 = 3'd1;
  localparam logic [2:0] IDX_DATA = 3'd2;
  localparam logic [2:0] IDX_STAT = 3'd3;
  localparam logic [2:0] IDX_PRE  = 3'd4;
  localparam logic [2:0] IDX_IRQ  = 3'd5;
  localparam logic [CNT_W-1:0] HALF_MARK = CNT_W'(FIFO_DEPTH / 2);

  logic [15:0] cfg0Reg;
  logic [6:0]  cfg1Reg;
  logic [7:0]  preReg;
  logic        rorFlag;

  shiftState_t state;
  logic [15:0] divCnt, halfPeriod;
  logic [5:0]  edgeCnt;
  logic        sclkReg;

  logic [2:0]  regIdx;
  logic        wrAcc, rdAcc;
  logic        cpol, cpha, portOn;
  logic        rxIrq, txIrq, rorIrq, busy;
  logic [6:0]  preHalf;
  logic [8:0]  scrPlus;
  logic [31:0] maskWide;
  logic        tick, leading, lastEdge, inXferTick, frameDone, rorSet;

  // Register decode
  assign regIdx = busAddr[4:2];
  assign wrAcc  = busSel && busWrite && (busAddr[1:0] == 2'b00);
  assign rdAcc  = busSel && !busWrite && (busAddr[1:0] == 2'b00);

  assign cpha      = cfg0Reg[6];
  assign cpol      = cfg0Reg[7];
  assign frameBits = (cfg0Reg[3:0] < 4'd3) ? 5'd4 : {1'b0, cfg0Reg[3:0]} + 5'd1;
  assign loopback  = cfg1Reg[3];
  assign portOn    = cfg1Reg[4];
  assign maskWide  = (32'd1 << frameBits) - 32'd1;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cfg0Reg <= '0;
      cfg1Reg <= '0;
      preReg  <= '0;
      rorFlag <= 1'b0;
    end else begin
      if (wrAcc && regIdx == IDX_CFG0) begin
        if (busByteEn[0]) cfg0Reg[7:0]  <= busWrData[7:0];
        if (busByteEn[1]) cfg0Reg[15:8] <= busWrData[15:8];
      end
      if (wrAcc && regIdx == IDX_CFG1 && busByteEn[0]) cfg1Reg <= busWrData[6:0];
      if (wrAcc && regIdx == IDX_PRE && busByteEn[0]) preReg <= {busWrData[7:1], 1'b0};
      if (wrAcc && regIdx == IDX_IRQ) rorFlag <= 1'b0;
      if (rorSet) rorFlag <= 1'b1;
    end
  end

  // Host side strobes
  assign strobe.hostPush = wrAcc && regIdx == IDX_DATA && (|busByteEn) && !txFull;
  assign strobe.hostPop  = rdAcc && regIdx == IDX_DATA && !rxEmpty;
  assign hostData = {busByteEn[1] ? busWrData[15:8] : 8'h00,
                     busByteEn[0] ? busWrData[7:0]  : 8'h00} & maskWide[15:0];

  // Interrupts and status
  assign rxIrq  = cfg1Reg[0] && (rxCount >= HALF_MARK);
  assign txIrq  = cfg1Reg[1] && (txCount <= HALF_MARK);
  assign rorIrq = cfg1Reg[2] && rorFlag;
  assign irq    = rxIrq || txIrq || rorIrq;
  assign busy   = (state != ST_IDLE) || !txEmpty;

  always_comb begin
    busRdData = '0;
    if (rdAcc) begin
      case (regIdx)
        IDX_CFG0: busRdData = cfg0Reg;
        IDX_CFG1: busRdData = {9'b0, cfg1Reg};
        IDX_DATA: busRdData = rxEmpty ? 16'h0000 : rxHead;
        IDX_STAT: busRdData = {11'b0, busy, rxFull, !rxEmpty, !txFull, txEmpty};
        IDX_PRE:  busRdData = {8'b0, preReg};
        IDX_IRQ:  busRdData = {13'b0, rorIrq, txIrq, rxIrq};
        default:  busRdData = '0;
      endcase
    end
  end

  // Serial clock timing
  assign preHalf    = (preReg[7:1] == 7'd0) ? 7'd1 : preReg[7:1];
  assign scrPlus    = {1'b0, cfg0Reg[15:8]} + 9'd1;
  assign halfPeriod = {9'b0, preHalf} * {7'b0, scrPlus};
  assign tick       = (divCnt == halfPeriod - 16'd1);

  assign leading    = !edgeCnt[0];
  assign lastEdge   = (edgeCnt == {frameBits, 1'b0} - 6'd1);
  assign inXferTick = portOn && (state == ST_XFER) && tick;
  assign frameDone  = inXferTick && lastEdge;
  assign rorSet     = frameDone && rxFull;

  assign strobe.load     = portOn && (state == ST_IDLE) && !txEmpty;
  assign strobe.sampleIn = inXferTick && (cpha ? !leading : leading);
  assign strobe.shiftOut = inXferTick && (cpha ? (leading && edgeCnt != 6'd0) : !leading);
  assign strobe.rxPush   = frameDone && !rxFull;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state   <= ST_IDLE;
      divCnt  <= '0;
      edgeCnt <= '0;
      sclkReg <= 1'b0;
      ssn     <= 1'b1;
    end else if (!portOn) begin
      state   <= ST_IDLE;
      divCnt  <= '0;
      sclkReg <= cpol;
      ssn     <= 1'b1;
    end else begin
      if (state == ST_IDLE) divCnt <= '0;
      else divCnt <= tick ? '0 : divCnt + 16'd1;
      case (state)
        ST_IDLE: begin
          sclkReg <= cpol;
          if (!txEmpty) begin
            state   <= ST_XFER;
            ssn     <= 1'b0;
            edgeCnt <= '0;
          end
        end
        ST_XFER: if (tick) begin
          sclkReg <= !sclkReg;
          edgeCnt <= edgeCnt + 6'd1;
          if (lastEdge) state <= ST_HOLD;
        end
        ST_HOLD: if (tick) begin
          ssn   <= 1'b1;
          state <= ST_GAP;
        end
        ST_GAP: if (tick) state <= ST_IDLE;
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign sclk = sclkReg;

  a_r3_select_high_idle: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_IDLE) |-> ssn);
  a_r8_overrun_sets_flag: assert property (@(posedge clk) disable iff (!rstN)
    rorSet |=> rorFlag);
  a_r11_disabled_quiet: assert property (@(posedge clk) disable iff (!rstN)
    !portOn |=> (ssn && state == ST_IDLE));
  a_r9_rx_irq_line: assert property (@(posedge clk) disable iff (!rstN)
    (cfg1Reg[0] && rxCount >= HALF_MARK) |-> irq);
  a_r5_idle_level: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_IDLE && $past(state == ST_IDLE) && $stable(cpol)) |-> (sclk == cpol));
endmodule

// File: rtl/sspm_top.sv
module sspm_top
  import sspm_pkg::*;
#(
  parameter int FIFO_DEPTH = 8
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        busSel,
  input  logic        busWrite,
  input  logic [4:0]  busAddr,
  input  logic [1:0]  busByteEn,
  input  logic [15:0] busWrData,
  output logic [15:0] busRdData,
  output logic        irq,
  output logic        sclk,
  output logic        mosi,
  output logic        ssn,
  input  logic        miso
);
  localparam int CNT_W = $clog2(FIFO_DEPTH + 1);

  dpStrobe_t          strobe;
  logic [FRAME_W-1:0] hostData, rxHead;
  logic [4:0]         frameBits;
  logic               loopback, txEmpty, txFull, rxEmpty, rxFull;
  logic [CNT_W-1:0]   txCount, rxCount;

  sspm_ctrl #(.FIFO_DEPTH(FIFO_DEPTH), .CNT_W(CNT_W)) ctrl_i (
    .clk(clk), .rstN(rstN), .busSel(busSel), .busWrite(busWrite),
    .busAddr(busAddr), .busByteEn(busByteEn), .busWrData(busWrData),
    .busRdData(busRdData), .irq(irq), .sclk(sclk), .ssn(ssn),
    .strobe(strobe), .hostData(hostData), .frameBits(frameBits),
    .loopback(loopback), .rxHead(rxHead), .txCount(txCount),
    .rxCount(rxCount), .txEmpty(txEmpty), .txFull(txFull),
    .rxEmpty(rxEmpty), .rxFull(rxFull));

  sspm_dpath #(.FIFO_DEPTH(FIFO_DEPTH), .CNT_W(CNT_W)) dpath_i (
    .clk(clk), .rstN(rstN), .strobe(strobe), .hostData(hostData),
    .frameBits(frameBits), .loopback(loopback), .misoIn(miso),
    .mosiOut(mosi), .rxHead(rxHead), .txCount(txCount), .rxCount(rxCount),
    .txEmpty(txEmpty), .txFull(txFull), .rxEmpty(rxEmpty), .rxFull(rxFull));
endmodule

// File: tb/sspm_top_tb_top.sv
`timescale 1ns/1ps
module sspm_top_tb_top;
  localparam logic [4:0] A_CFG0 = 5'h00, A_CFG1 = 5'h04, A_DATA = 5'h08;
  localparam logic [4:0] A_STAT = 5'h0C, A_PRE = 5'h10, A_IRQ = 5'h14;

  logic clk = 1'b0, rstN = 1'b0;
  logic busSel = 1'b0, busWrite = 1'b0;
  logic [4:0] busAddr = '0;
  logic [1:0] busByteEn = 2'b11;
  logic [15:0] busWrData = '0, busRdData;
  logic irq, sclk, mosi, ssn, miso;

  int checks = 0, fails = 0;
  int curBits = 8;
  bit cpolB = 1'b0, cphaB = 1'b0, finished = 1'b0;
  logic [15:0] expQ[$];
  logic [15:0] rd;

  always #4 clk = !clk;
  assign miso = !mosi;

  sspm_top dut_i (.clk(clk), .rstN(rstN), .busSel(busSel), .busWrite(busWrite),
    .busAddr(busAddr), .busByteEn(busByteEn), .busWrData(busWrData),
    .busRdData(busRdData), .irq(irq), .sclk(sclk), .mosi(mosi), .ssn(ssn),
    .miso(miso));

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  function automatic logic [15:0] maskOf(input int bits);
    return 16'((32'd1 << bits) - 1);
  endfunction

  task automatic regWr(input logic [4:0] a, input logic [15:0] d, input logic [1:0] be = 2'b11);
    @(negedge clk);
    busSel = 1'b1; busWrite = 1'b1; busAddr = a; busWrData = d; busByteEn = be;
    @(negedge clk);
    busSel = 1'b0; busWrite = 1'b0; busByteEn = 2'b11;
  endtask

  task automatic regRd(input logic [4:0] a, output logic [15:0] d);
    @(negedge clk);
    busSel = 1'b1; busWrite = 1'b0; busAddr = a;
    #1 d = busRdData;
    @(negedge clk);
    busSel = 1'b0;
  endtask

  // Driver: queue a frame and record what the serial side must show.
  task automatic sendFrame(input logic [15:0] v);
    expQ.push_back(v & maskOf(curBits));
    regWr(A_DATA, v);
  endtask

  task automatic setMode(input bit pol, input bit pha, input logic [3:0] code,
                         input logic [7:0] scr, input logic [7:0] pre);
    cpolB = pol; cphaB = pha;
    curBits = (code < 3) ? 4 : int'(code) + 1;
    regWr(A_CFG0, {scr, pol, pha, 2'b00, code});
    regWr(A_PRE, {8'h00, pre});
  endtask

  task automatic waitIdle();
    logic [15:0] s;
    for (int i = 0; i < 4000; i++) begin
      regRd(A_STAT, s);
      if (!s[4]) break;
    end
  endtask

  // Monitor: rebuild frames at the sampling edge and compare with the queue.
  always @(negedge ssn) begin
    logic [15:0] cap, e;
    int n;
    cap = '0; n = 0;
    while (ssn === 1'b0) begin
      @(sclk or ssn);
      if (ssn === 1'b0 && sclk === (cphaB ? cpolB : !cpolB)) begin
        cap = {cap[14:0], mosi};
        n++;
      end
    end
    if (expQ.size() == 0) chk(1'b0, "R3 unexpected serial frame", cap, 0);
    else begin
      e = expQ.pop_front();
      chk(cap == e && n == curBits, "R3 R5 serial frame content", cap, e);
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      checks++; fails++;
      $display("FAIL watchdog expired actual=0x0 expected=0x1");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [15:0] pat [3];
    realtime t0, t1;
    bit quiet;
    logic s0;
    pat[0] = 16'hA5; pat[1] = 16'h3C; pat[2] = 16'h81;
    repeat (4) @(negedge clk);
    rstN = 1'b1;

    // R1 reset state
    regRd(A_STAT, rd); chk(rd == 16'h0003, "R1 status after reset", rd, 16'h0003);
    chk(ssn == 1'b1 && sclk == 1'b0 && irq == 1'b0, "R1 pins after reset",
        {ssn, sclk, irq}, 3'b100);
    regRd(A_CFG1, rd); chk(rd == 16'h0, "R1 control 1 after reset", rd, 0);

    // R2 register readback and byte enables
    regWr(A_CFG0, 16'hABC7); regRd(A_CFG0, rd); chk(rd == 16'hABC7, "R2 control 0", rd, 16'hABC7);
    regWr(A_CFG0, 16'h55FF, 2'b10); regRd(A_CFG0, rd); chk(rd == 16'h55C7, "R2 byte enable", rd, 16'h55C7);
    regWr(A_PRE, 16'h0007); regRd(A_PRE, rd); chk(rd == 16'h0006, "R2 prescale bit0", rd, 16'h0006);
    regWr(A_CFG1, 16'h0065); regRd(A_CFG1, rd); chk(rd == 16'h0065, "R2 control 1", rd, 16'h0065);
    regWr(A_CFG1, 16'h0000); regRd(A_CFG1, rd); chk(rd == 16'h0, "R11 write zero disables", rd, 0);

    // R12 empty read
    regRd(A_DATA, rd); chk(rd == 16'h0, "R12 empty receive read", rd, 0);

    // R5 R6 all four modes under loopback
    for (int m = 0; m < 4; m++) begin
      setMode(m[1], m[0], 4'd7, 8'd0, 8'd2);
      regWr(A_CFG1, 16'h0018);
      for (int k = 0; k < 3; k++) sendFrame(pat[k] + 16'(m));
      waitIdle();
      chk(sclk == cpolB, "R5 idle clock level", sclk, cpolB);
      for (int k = 0; k < 3; k++) begin
        regRd(A_DATA, rd);
        chk(rd == pat[k] + 16'(m), "R6 loopback receive", rd, pat[k] + 16'(m));
      end
    end

    // R3 widths
    setMode(1'b0, 1'b0, 4'd15, 8'd0, 8'd2);
    sendFrame(16'hBEEF); sendFrame(16'h1234); waitIdle();
    regRd(A_DATA, rd); chk(rd == 16'hBEEF, "R3 16-bit frame", rd, 16'hBEEF);
    regRd(A_DATA, rd); chk(rd == 16'h1234, "R3 16-bit frame", rd, 16'h1234);
    setMode(1'b0, 1'b1, 4'd3, 8'd0, 8'd2);
    sendFrame(16'h00FA); waitIdle();
    regRd(A_DATA, rd); chk(rd == 16'h000A, "R3 4-bit frame masked", rd, 16'h000A);
    setMode(1'b1, 1'b0, 4'd1, 8'd0, 8'd2);
    sendFrame(16'h003C); waitIdle();
    regRd(A_DATA, rd); chk(rd == 16'h000C, "R3 low code gives 4 bits", rd, 16'h000C);

    // R4 clock rate: prescale 5 counts as 4, SCR 2 -> half period 6 cycles
    setMode(1'b0, 1'b0, 4'd7, 8'd2, 8'd5);
    sendFrame(16'h00C3);
    @(posedge sclk); t0 = $realtime;
    @(posedge sclk); t1 = $realtime;
    chk((t1 - t0) == 96.0, "R4 serial clock period ns", int'(t1 - t0), 96);
    waitIdle();
    regRd(A_DATA, rd); chk(rd == 16'h00C3, "R4 frame at slow rate", rd, 16'h00C3);

    // R6 pin path: input is the inverse of output
    setMode(1'b0, 1'b0, 4'd7, 8'd0, 8'd2);
    regWr(A_CFG1, 16'h0010);
    sendFrame(16'h005A); waitIdle();
    regRd(A_DATA, rd); chk(rd == 16'h00A5, "R6 pin receive", rd, 16'h00A5);

    // R7 R9 R10 R11 fill while disabled, interrupts enabled, loopback
    regWr(A_CFG1, 16'h000F);
    for (int k = 0; k < 4; k++) sendFrame(16'h10 + 16'(k));
    regRd(A_IRQ, rd); chk(rd == 16'h0002, "R9 transmit half mark", rd, 16'h0002);
    chk(irq == 1'b1, "R9 line from transmit", irq, 1);
    for (int k = 4; k < 8; k++) sendFrame(16'h10 + 16'(k));
    regRd(A_IRQ, rd); chk(rd == 16'h0000, "R9 transmit above half", rd, 0);
    regWr(A_DATA, 16'h00EE);
    regRd(A_STAT, rd); chk(rd == 16'h0010, "R7 R10 full transmit status", rd, 16'h0010);
    quiet = 1'b1; s0 = sclk;
    repeat (20) begin
      @(negedge clk);
      if (ssn !== 1'b1 || sclk !== s0) quiet = 1'b0;
    end
    chk(quiet, "R11 no shifting while disabled", quiet, 1);
    regWr(A_CFG1, 16'h001F);
    regRd(A_STAT, rd); chk(rd[4] == 1'b1, "R10 busy while shifting", rd[4], 1);
    waitIdle();
    regRd(A_STAT, rd); chk(rd == 16'h000F, "R7 receive full status", rd, 16'h000F);
    regRd(A_IRQ, rd); chk(rd == 16'h0003, "R9 receive half mark", rd, 16'h0003);

    // R8 overrun
    sendFrame(16'h0077); waitIdle();
    regRd(A_IRQ, rd); chk(rd == 16'h0007, "R8 overrun flagged", rd, 16'h0007);
    regWr(A_IRQ, 16'h0000);
    regRd(A_IRQ, rd); chk(rd == 16'h0003, "R8 overrun cleared", rd, 16'h0003);
    for (int k = 0; k < 8; k++) begin
      regRd(A_DATA, rd);
      chk(rd == 16'h10 + 16'(k), "R8 R7 kept frames", rd, 16'h10 + 16'(k));
    end
    regRd(A_STAT, rd); chk(rd == 16'h0003, "R7 drained status", rd, 16'h0003);
    regWr(A_CFG1, 16'h0018);
    @(negedge clk); chk(irq == 1'b0, "R9 gated off", irq, 0);

    chk(expQ.size() == 0, "R3 all frames seen", expQ.size(), 0);
    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule